// File: doc/BRIEF.md
# GPIO Output Source Multiplexer

This block is the output stage of a general purpose I/O bank. For each pad, a 5-bit selector chooses where the pad's level comes from. It can pick a bit that software writes, or one bit of a small vector of internal hardware signals. A 2-bit drive mode per pad decides whether the pad is driven or left floating. Software programs the block through a simple word-addressed register port. The same port returns the pad input levels, which pass through a two-flop synchronizer first.

Selector fields are packed six pads to a 32-bit word, each field 5 bits wide. Drive-mode fields are packed sixteen pads to a word, each field 2 bits wide. With the default 18 pads, the word addresses are:

| Address | Contents |
|---|---|
| 0, 1, 2 | selector words |
| 3, 4 | drive-mode words |
| 5 | software output bits |
| 6 | synchronized input levels, read-only |
| 7 | unmapped |

The register port has no back-pressure. It accepts a request in every cycle in which `req_valid` is high. A read answers exactly one cycle later with `rsp_valid`. The port has no ready signal, so the master must be able to take a response in every cycle. The hardware signal vector and the pad inputs are plain level inputs.

Top module: `gpio_out_mux`

## Requirements
- R1: All registers reset to 0. While reset is asserted, `pad_oe` and `pad_out` are 0. After reset, every mapped address reads 0 while the pad inputs are low.
- R2: The selector of pad p is held in word p/6, bits [(p mod 6)*5 +: 5]. A write sets all six fields of that word at once, and a read returns them. Bits 31:30 of a selector word read as 0, and so do the fields of pads that do not exist.
- R3: Selector code 0 drives the pad with bit p of the software output word, address 5. Only bits below the pad count are stored there, and the word reads back with those bits.
- R4: Selector codes 1 to 6 drive the pad with `hw_sig` bit (code-1).
- R5: Selector codes 7 to 31 drive the pad low.
- R6: The drive mode of pad p is held in word 3 + p/16, bits [(p mod 16)*2 +: 2]. Mode 2'b11 drives the pad, which sets `pad_oe[p]` to 1. Modes 00, 01 and 10 leave the pad floating. Bits of a drive-mode word that belong to no pad read as 0.
- R7: Whenever `pad_oe[p]` is 0, `pad_out[p]` is 0.
- R8: Address 6 returns the pad input levels after two synchronizer flops. A read accepted on the second clock edge after a change still returns the old level; a read accepted on the third edge returns the new one. Writes to address 6 have no effect.
- R9: A read accepted at a clock edge raises `rsp_valid` for exactly the next cycle, with the data in `rsp_rdata`. Writes and idle cycles produce no response.
- R10: Writes to an unmapped address (7) change no register and no pad. Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (3) | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| hw_sig | input | NUM_SRC (6) | Internal hardware signal sources |
| pad_in | input | NUM_PINS (18) | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS (18) | Level driven on each pad |
| pad_oe | output | NUM_PINS (18) | Drive enable for each pad |

## Verification
The assertions assume that `req_write` and `req_addr` are known whenever `req_valid` is high. They also assume that a read response can always be taken in the next cycle, so the response checks can tie `rsp_valid` to the read accepted one edge earlier. The drive-mode check looks only at `pad_oe`, which depends on no asynchronous input, so it does not care how `hw_sig` or `pad_in` move. The stimulus changes every input on the falling clock edge, issues one request at a time, and changes `pad_in` only where the synchronizer latency is under test.

// File: rtl/gpio_out_mux_pkg.sv
package gpio_out_mux_pkg;
  localparam int REG_W        = 32;
  localparam int SEL_W        = 5;
  localparam int PINS_PER_SEL = 6;
  localparam int MODE_W       = 2;
  localparam int PINS_PER_OE  = REG_W / MODE_W;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_DRIVE = '1;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int oe_base(input int pins);
    return ceil_div(pins, PINS_PER_SEL);
  endfunction

  function automatic int dout_addr(input int pins);
    return oe_base(pins) + ceil_div(pins, PINS_PER_OE);
  endfunction

  function automatic int din_addr(input int pins);
    return dout_addr(pins) + 1;
  endfunction
endpackage

// File: rtl/gpio_out_mux_sync.sv
module gpio_out_mux_sync #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_out_mux_regs.sv
module gpio_out_mux_regs
  import gpio_out_mux_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic [NUM_PINS-1:0] din_sync,
  output sel_t              sel_o  [NUM_PINS],
  output mode_t             mode_o [NUM_PINS],
  output logic [NUM_PINS-1:0] dout_o,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata
);
  localparam int A_OE   = oe_base(NUM_PINS);
  localparam int A_DOUT = dout_addr(NUM_PINS);
  localparam int A_DIN  = din_addr(NUM_PINS);

  sel_t              sel_q  [NUM_PINS];
  mode_t             mode_q [NUM_PINS];
  logic [NUM_PINS-1:0] dout_q;
  logic [REG_W-1:0]  rd_word;
  logic              wr_fire;
  logic              rd_fire;

  assign wr_fire = req_valid && req_write;
  assign rd_fire = req_valid && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        sel_q[p]  <= '0;
        mode_q[p] <= '0;
      end
      dout_q <= '0;
    end else if (wr_fire) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (req_addr == ADDR_W'(p / PINS_PER_SEL))
          sel_q[p] <= req_wdata[(p % PINS_PER_SEL)*SEL_W +: SEL_W];
        if (req_addr == ADDR_W'(A_OE + p / PINS_PER_OE))
          mode_q[p] <= req_wdata[(p % PINS_PER_OE)*MODE_W +: MODE_W];
        if (req_addr == ADDR_W'(A_DOUT))
          dout_q[p] <= req_wdata[p];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (req_addr == ADDR_W'(p / PINS_PER_SEL))
        rd_word[(p % PINS_PER_SEL)*SEL_W +: SEL_W] = sel_q[p];
      if (req_addr == ADDR_W'(A_OE + p / PINS_PER_OE))
        rd_word[(p % PINS_PER_OE)*MODE_W +: MODE_W] = mode_q[p];
      if (req_addr == ADDR_W'(A_DOUT))
        rd_word[p] = dout_q[p];
      if (req_addr == ADDR_W'(A_DIN))
        rd_word[p] = din_sync[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_word;
    end
  end

  assign sel_o  = sel_q;
  assign mode_o = mode_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/gpio_out_mux_pin.sv
module gpio_out_mux_pin
  import gpio_out_mux_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  sel_t               sel,
  input  mode_t              mode,
  input  logic               sw_bit,
  input  logic [NUM_SRC-1:0] hw_sig,
  output logic               pad_out,
  output logic               pad_oe
);
  logic src_bit;
  logic drive;

  always_comb begin
    src_bit = 1'b0;
    if (sel == '0) src_bit = sw_bit;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel == SEL_W'(k + 1)) src_bit = hw_sig[k];
    end
  end

  assign drive   = (mode == MODE_DRIVE);
  assign pad_oe  = drive;
  assign pad_out = drive & src_bit;
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
  import gpio_out_mux_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int NUM_SRC  = 6,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_SRC-1:0]  hw_sig,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  sel_t                sel  [NUM_PINS];
  mode_t               mode [NUM_PINS];
  logic [NUM_PINS-1:0] dout;
  logic [NUM_PINS-1:0] din_sync;

  gpio_out_mux_sync #(.W(NUM_PINS)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_in),
    .sync_o  (din_sync)
  );

  gpio_out_mux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .din_sync  (din_sync),
    .sel_o     (sel),
    .mode_o    (mode),
    .dout_o    (dout),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_out_mux_pin #(.NUM_SRC(NUM_SRC)) pin_i (
      .sel     (sel[p]),
      .mode    (mode[p]),
      .sw_bit  (dout[p]),
      .hw_sig  (hw_sig),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p])
    );
  end
endmodule

// File: rtl/gpio_out_mux_chk.sv
module gpio_out_mux_chk
  import gpio_out_mux_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [31:0]         req_wdata,
  input logic                rsp_valid,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);
  localparam int A_OE  = oe_base(NUM_PINS);
  localparam int A_DIN = din_addr(NUM_PINS);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0));

  a_r9_rsp_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r7_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r10_bad_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr > ADDR_W'(A_DIN)) |=> $stable(pad_oe));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    a_r6_mode_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(A_OE + p / PINS_PER_OE))
      |=> pad_oe[p] == (&$past(req_wdata[(p % PINS_PER_OE)*MODE_W +: MODE_W])));
  end
endmodule

bind gpio_out_mux gpio_out_mux_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_out_mux_tb_top.sv
module gpio_out_mux_tb_top;
  localparam int NP = 18;
  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NS-1:0] hw_sig = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  logic [4:0]  sel_m  [NP];
  logic [1:0]  mode_m [NP];
  logic [NP-1:0] dout_m;

  always #10 clk = ~clk;

  gpio_out_mux dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .hw_sig(hw_sig), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  function automatic logic [31:0] sel_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 6; k++)
      if (w*6 + k < NP) r[k*5 +: 5] = sel_m[w*6 + k];
    return r;
  endfunction

  function automatic logic [31:0] mode_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 16; k++)
      if (w*16 + k < NP) r[k*2 +: 2] = mode_m[w*16 + k];
    return r;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_sel(input int w, input logic [4:0] c0, c1, c2, c3, c4, c5);
    logic [4:0] c [6];
    c = '{c0, c1, c2, c3, c4, c5};
    for (int k = 0; k < 6; k++) if (w*6 + k < NP) sel_m[w*6 + k] = c[k];
    bus_write(3'(w), sel_word(w) | 32'hC000_0000);
  endtask

  task automatic write_modes(input int w, input logic [31:0] d);
    for (int k = 0; k < 16; k++) if (w*16 + k < NP) mode_m[w*16 + k] = d[k*2 +: 2];
    bus_write(3'(3 + w), d);
  endtask

  task automatic check_pads(input string t);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      logic s;
      if (sel_m[p] == 0) s = dout_m[p];
      else if (sel_m[p] <= 6) s = hw_sig[sel_m[p] - 1];
      else s = 1'b0;
      ee[p] = (mode_m[p] == 2'b11);
      eo[p] = ee[p] & s;
    end
    check(pad_oe === ee, {t, " pad_oe"}, 32'(pad_oe), 32'(ee));
    check(pad_out === eo, {t, " pad_out"}, 32'(pad_out), 32'(eo));
  endtask

  task automatic finish_run();
    check(exp_q.size() == 0, "R9 missing responses", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin sel_m[p] = '0; mode_m[p] = '0; end
    dout_m = '0;
    repeat (3) @(negedge clk);
    check(pad_oe === '0 && pad_out === '0, "R1 pads during reset",
          32'({pad_oe, pad_out}), 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) bus_read(3'(a), 32'h0, "R1 reset value");
    bus_read(3'd7, 32'h0, "R10 unmapped read");
    @(negedge clk);
    check_pads("R1 after reset");

    // R2 selector packing, bits 31:30 and absent pads read 0
    write_sel(0, 5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5);
    write_sel(1, 5'd6, 5'd7, 5'd31, 5'd0, 5'd3, 5'd2);
    write_sel(2, 5'd1, 5'd0, 5'd6, 5'd4, 5'd8, 5'd0);
    for (int w = 0; w < 3; w++) bus_read(3'(w), sel_word(w), "R2 selector readback");

    // R6 drive words, unused bits dropped
    write_modes(0, 32'hFFFF_FFFF);
    write_modes(1, 32'hFFFF_FFFF);
    bus_read(3'd3, 32'hFFFF_FFFF, "R6 mode word 0");
    bus_read(3'd4, 32'h0000_000F, "R6 mode word 1");

    // R3/R4/R5 with several data and signal patterns
    dout_m = 18'h2_A5A5;
    bus_write(3'd5, 32'hFFFC_0000 | 32'(dout_m));
    bus_read(3'd5, 32'(dout_m), "R3 sw word readback");
    @(negedge clk); hw_sig = 6'b000000;
    @(negedge clk); check_pads("R3/R4/R5 pattern A");
    hw_sig = 6'b111111;
    @(negedge clk); check_pads("R3/R4/R5 pattern B");
    hw_sig = 6'b101010;
    @(negedge clk); check_pads("R4 pattern C");
    dout_m = 18'h1_5A5A;
    bus_write(3'd5, 32'(dout_m));
    hw_sig = 6'b010101;
    @(negedge clk); check_pads("R3/R4 pattern D");
    write_sel(0, 5'd7, 5'd15, 5'd31, 5'd0, 5'd6, 5'd1);
    hw_sig = 6'b111111;
    @(negedge clk); check_pads("R5 high codes drive low");

    // R6/R7 mixed drive modes
    write_modes(0, 32'h1B1B_E4E4);
    write_modes(1, 32'h0000_0006);
    @(negedge clk); check_pads("R6/R7 mixed modes");
    bus_read(3'd3, 32'h1B1B_E4E4, "R6 mode readback");

    // R10 unmapped write changes nothing
    bus_write(3'd7, 32'hFFFF_FFFF);
    @(negedge clk); check_pads("R10 pads after unmapped write");
    for (int w = 0; w < 3; w++) bus_read(3'(w), sel_word(w), "R10 selectors kept");
    bus_read(3'd3, mode_word(0), "R10 modes kept");
    bus_read(3'd5, 32'(dout_m), "R10 sw word kept");

    // R8 synchronizer latency and write-ignore
    bus_write(3'd6, 32'hFFFF_FFFF);
    bus_read(3'd6, 32'h0, "R8 input write ignored");
    @(negedge clk);
    pad_in = 18'h2_C3A5;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd6;
    exp_q.push_back(32'h0); tag_q.push_back("R8 first edge old");
    @(negedge clk);
    exp_q.push_back(32'h0); tag_q.push_back("R8 second edge old");
    @(negedge clk);
    exp_q.push_back(32'h0002_C3A5); tag_q.push_back("R8 third edge new");
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 idle no response", 32'(rsp_valid), 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule